// File: doc/BRIEF.md
# Multi-Event Buffer Busy Tracker

This block sits at the back end of a pixel readout chip. It watches two separate resources: a small pool of per-pixel event buffer slices and an event framing queue. A strobe trigger takes one slice if one is free, and a slice returns to the pool when readout of its event ends. Every trigger, whether or not it got a slice, puts one entry into the framing queue. The entry records whether the event is empty. An entry leaves the queue when its frame has been sent.

The chip is busy when no slice is free or when the framing queue holds more than a set number of events. Each change of the busy state is announced in the outgoing word stream. An announce word has priority over the data words, so it can cut into a frame. The data word that was waiting stays with the sender and goes out unchanged on the next free cycle. Two counters, one for all triggers and one for accepted triggers, let readout efficiency be worked out as their ratio.

Top module: `meb_busy_tracker`

## Requirements
- R1: After a synchronous reset, all slices are free, the framing queue is empty, busy is low, both counters are zero and no busy word is pending.
- R2: A trigger that arrives while at least one slice is free takes one slice and increments both the total and the accepted counter on the next clock edge.
- R3: A trigger that arrives while no slice is free increments only the total counter and leaves the slice count at zero. It still queues a framing entry, and that entry is marked empty (head_empty_o reads 1 when it reaches the head of the queue).
- R4: A slice release adds one free slice. A release is ignored when all slices are already free. A release and an accepted trigger in the same cycle leave the free count unchanged.
- R5: The framing queue holds up to Q_DEPTH entries (default 64) in arrival order. Each trigger adds one entry unless the queue is full, and frame_done_i removes the oldest entry unless the queue is empty. head_empty_o shows the mark of the oldest entry and reads 0 when the queue is empty.
- R6: busy_o is high exactly when the free slice count is zero or the queue fill exceeds BUSY_LEVEL (default 48). It follows the state registered at the last clock edge.
- R7: When busy_o differs from the last announced state, the output carries a busy word: dout_kind_o is 2'b01 for a busy-on word and 2'b10 for a busy-off word, and dout_data_o is zero. Data words carry dout_kind_o 2'b00.
- R8: While a busy word is presented, din_ready_o is low. Otherwise the output passes din_valid_i and din_data_i straight through and din_ready_o equals dout_ready_i.
- R9: Each busy word is announced once, and the announced state changes only when the word is accepted with dout_ready_i high. If busy returns to the announced state before the word is accepted, no word is sent.
- R10: The accepted counter never exceeds the total counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| trig_i | input | 1 | Strobe trigger |
| slice_rel_i | input | 1 | Readout of one event finished, its slice is released |
| frame_done_i | input | 1 | Oldest frame sent, its queue entry is removed |
| din_valid_i | input | 1 | Incoming data word valid |
| din_data_i | input | DATA_W | Incoming data word |
| din_ready_o | output | 1 | Incoming data word accepted |
| dout_valid_o | output | 1 | Outgoing word valid |
| dout_kind_o | output | 2 | Outgoing word kind: 00 data, 01 busy-on, 10 busy-off |
| dout_data_o | output | DATA_W | Outgoing word payload |
| dout_ready_i | input | 1 | Downstream takes the outgoing word |
| busy_o | output | 1 | Busy condition |
| slices_free_o | output | SLICE_W | Free event buffer slices |
| frames_o | output | FILL_W | Framing queue fill |
| head_empty_o | output | 1 | Empty mark of the oldest queued event |
| trig_total_o | output | CNT_W | Triggers seen |
| trig_accept_o | output | CNT_W | Triggers that got a slice |

## Verification
Two pairs of functions can fall in the same cycle. The first is a change of busy state while a data word waits with din_valid_i high. The bench holds the data valid across the busy edges and stalls dout_ready_i, then checks that the busy word wins, that din_ready_o stays low and that the data word goes through on the first free cycle. The second is a slice allocation together with a release. The bench drives both while slices are partly used, while none are free, and while all are free, and it also lets busy clear before its announce word is taken. Every cycle is compared with a bench model built from the requirements.

// File: rtl/meb_pkg.sv
package meb_pkg;

    typedef enum logic [1:0] {
        KIND_DATA = 2'b00,
        KIND_ON   = 2'b01,
        KIND_OFF  = 2'b10
    } word_kind_e;

    typedef struct packed {
        logic trig;
        logic rel;
        logic done;
    } evt_ctl_t;

    function automatic word_kind_e announce_kind(input logic busy_now);
        return busy_now ? KIND_ON : KIND_OFF;
    endfunction

endpackage

// File: rtl/meb_slice_pool.sv
module meb_slice_pool #(
    parameter int N_SLICE = 3,
    localparam int SLICE_W = $clog2(N_SLICE + 1)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               trig,
    input  logic               rel,
    output logic               accept,
    output logic [SLICE_W-1:0] free_cnt,
    output logic               none_free
);
    logic [SLICE_W-1:0] free_q;
    logic               rel_eff;

    assign accept    = trig && (free_q != '0);
    assign rel_eff   = rel && (free_q != SLICE_W'(N_SLICE));
    assign none_free = (free_q == '0);
    assign free_cnt  = free_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            free_q <= SLICE_W'(N_SLICE);
        end else begin
            free_q <= free_q + SLICE_W'(rel_eff) - SLICE_W'(accept);
        end
    end

    assert_free_bound_R4: assert property (@(posedge clk) disable iff (rst)
        free_q <= SLICE_W'(N_SLICE));

    assert_swap_same_R4: assert property (@(posedge clk) disable iff (rst)
        (trig && rel && free_q != '0 && free_q != SLICE_W'(N_SLICE)) |=> $stable(free_q));

    assert_reject_stays_R3: assert property (@(posedge clk) disable iff (rst)
        (trig && !rel && free_q == '0) |=> (free_q == '0));

endmodule

// File: rtl/meb_frame_queue.sv
module meb_frame_queue #(
    parameter int Q_DEPTH    = 64,
    parameter int BUSY_LEVEL = 48,
    localparam int FILL_W = $clog2(Q_DEPTH + 1),
    localparam int PTR_W  = $clog2(Q_DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              push,
    input  logic              mark_empty,
    input  logic              pop,
    output logic [FILL_W-1:0] fill,
    output logic              head_empty,
    output logic              over_level
);
    logic [Q_DEPTH-1:0] marks_q;
    logic [PTR_W-1:0]   wr_q, rd_q;
    logic [FILL_W-1:0]  fill_q;
    logic               push_eff, pop_eff;

    function automatic logic [PTR_W-1:0] ptr_next(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(Q_DEPTH - 1)) ? '0 : p + PTR_W'(1);
    endfunction

    assign push_eff   = push && (fill_q != FILL_W'(Q_DEPTH));
    assign pop_eff    = pop && (fill_q != '0);
    assign fill       = fill_q;
    assign head_empty = (fill_q != '0) && marks_q[rd_q];
    assign over_level = (fill_q > FILL_W'(BUSY_LEVEL));

    always_ff @(posedge clk) begin
        if (rst) begin
            marks_q <= '0;
            wr_q    <= '0;
            rd_q    <= '0;
            fill_q  <= '0;
        end else begin
            if (push_eff) begin
                marks_q[wr_q] <= mark_empty;
                wr_q          <= ptr_next(wr_q);
            end
            if (pop_eff) begin
                rd_q <= ptr_next(rd_q);
            end
            fill_q <= fill_q + FILL_W'(push_eff) - FILL_W'(pop_eff);
        end
    end

    assert_fill_bound_R5: assert property (@(posedge clk) disable iff (rst)
        fill_q <= FILL_W'(Q_DEPTH));

    assert_push_grows_R5: assert property (@(posedge clk) disable iff (rst)
        (push && !pop && fill_q < FILL_W'(Q_DEPTH)) |=> (fill_q == $past(fill_q) + FILL_W'(1)));

    assert_pop_shrinks_R5: assert property (@(posedge clk) disable iff (rst)
        (pop && !push && fill_q != '0) |=> (fill_q == $past(fill_q) - FILL_W'(1)));

endmodule

// File: rtl/meb_busy_merge.sv
module meb_busy_merge
    import meb_pkg::*;
#(
    parameter int DATA_W = 24
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              busy,
    input  logic              din_valid,
    input  logic [DATA_W-1:0] din_data,
    output logic              din_ready,
    output logic              dout_valid,
    output word_kind_e        dout_kind,
    output logic [DATA_W-1:0] dout_data,
    input  logic              dout_ready
);
    logic said_busy_q;
    logic announce;

    assign announce   = (busy != said_busy_q);
    assign dout_valid = announce || din_valid;
    assign dout_kind  = announce ? announce_kind(busy) : KIND_DATA;
    assign dout_data  = announce ? '0 : din_data;
    assign din_ready  = dout_ready && !announce;

    always_ff @(posedge clk) begin
        if (rst) begin
            said_busy_q <= 1'b0;
        end else if (announce && dout_ready) begin
            said_busy_q <= busy;
        end
    end

    assert_on_while_busy_R7: assert property (@(posedge clk) disable iff (rst)
        (dout_valid && dout_kind == KIND_ON) |-> busy);

    assert_off_while_idle_R7: assert property (@(posedge clk) disable iff (rst)
        (dout_valid && dout_kind == KIND_OFF) |-> !busy);

    assert_word_once_R9: assert property (@(posedge clk) disable iff (rst)
        (dout_valid && dout_kind != KIND_DATA && dout_ready && $stable(busy))
            |=> !(dout_valid && dout_kind == $past(dout_kind)) || (busy != $past(busy)));

    assert_data_blocked_R8: assert property (@(posedge clk) disable iff (rst)
        (dout_kind != KIND_DATA) |-> !din_ready);

endmodule

// File: rtl/meb_busy_tracker.sv
module meb_busy_tracker
    import meb_pkg::*;
#(
    parameter int N_SLICE    = 3,
    parameter int Q_DEPTH    = 64,
    parameter int BUSY_LEVEL = 48,
    parameter int DATA_W     = 24,
    parameter int CNT_W      = 16,
    localparam int SLICE_W = $clog2(N_SLICE + 1),
    localparam int FILL_W  = $clog2(Q_DEPTH + 1)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               trig_i,
    input  logic               slice_rel_i,
    input  logic               frame_done_i,
    input  logic               din_valid_i,
    input  logic [DATA_W-1:0]  din_data_i,
    output logic               din_ready_o,
    output logic               dout_valid_o,
    output logic [1:0]         dout_kind_o,
    output logic [DATA_W-1:0]  dout_data_o,
    input  logic               dout_ready_i,
    output logic               busy_o,
    output logic [SLICE_W-1:0] slices_free_o,
    output logic [FILL_W-1:0]  frames_o,
    output logic               head_empty_o,
    output logic [CNT_W-1:0]   trig_total_o,
    output logic [CNT_W-1:0]   trig_accept_o
);
    evt_ctl_t   ctl;
    logic       accept, none_free, over_level;
    word_kind_e kind;
    logic [CNT_W-1:0] total_q, accept_q;

    assign ctl = '{trig: trig_i, rel: slice_rel_i, done: frame_done_i};

    meb_slice_pool #(.N_SLICE(N_SLICE)) u_pool (
        .clk       (clk),
        .rst       (rst),
        .trig      (ctl.trig),
        .rel       (ctl.rel),
        .accept    (accept),
        .free_cnt  (slices_free_o),
        .none_free (none_free)
    );

    meb_frame_queue #(.Q_DEPTH(Q_DEPTH), .BUSY_LEVEL(BUSY_LEVEL)) u_queue (
        .clk        (clk),
        .rst        (rst),
        .push       (ctl.trig),
        .mark_empty (!accept),
        .pop        (ctl.done),
        .fill       (frames_o),
        .head_empty (head_empty_o),
        .over_level (over_level)
    );

    assign busy_o = none_free || over_level;

    meb_busy_merge #(.DATA_W(DATA_W)) u_merge (
        .clk        (clk),
        .rst        (rst),
        .busy       (busy_o),
        .din_valid  (din_valid_i),
        .din_data   (din_data_i),
        .din_ready  (din_ready_o),
        .dout_valid (dout_valid_o),
        .dout_kind  (kind),
        .dout_data  (dout_data_o),
        .dout_ready (dout_ready_i)
    );

    assign dout_kind_o = kind;

    always_ff @(posedge clk) begin
        if (rst) begin
            total_q  <= '0;
            accept_q <= '0;
        end else begin
            total_q  <= total_q + CNT_W'(ctl.trig);
            accept_q <= accept_q + CNT_W'(accept);
        end
    end

    assign trig_total_o  = total_q;
    assign trig_accept_o = accept_q;

    assert_accept_le_total_R10: assert property (@(posedge clk) disable iff (rst)
        accept_q <= total_q);

    assert_total_step_R2: assert property (@(posedge clk) disable iff (rst)
        ctl.trig |=> (total_q == $past(total_q) + CNT_W'(1)));

endmodule

// File: tb/meb_busy_tracker_tb.sv
module meb_busy_tracker_tb;
    localparam int DW = 24;

    logic          clk = 1'b0;
    logic          rst;
    logic          trig, rel, done, dv, dr;
    logic [DW-1:0] dd;
    logic          din_ready, dout_valid, busy, head_empty;
    logic [1:0]    dout_kind;
    logic [DW-1:0] dout_data;
    logic [1:0]    slices_free;
    logic [6:0]    frames;
    logic [15:0]   total, accepted;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    int m_free, m_total, m_acc;
    bit m_rep;
    bit mq[$];

    always #10 clk = ~clk;

    meb_busy_tracker u_dut (
        .clk(clk), .rst(rst), .trig_i(trig), .slice_rel_i(rel), .frame_done_i(done),
        .din_valid_i(dv), .din_data_i(dd), .din_ready_o(din_ready),
        .dout_valid_o(dout_valid), .dout_kind_o(dout_kind), .dout_data_o(dout_data),
        .dout_ready_i(dr), .busy_o(busy), .slices_free_o(slices_free),
        .frames_o(frames), .head_empty_o(head_empty),
        .trig_total_o(total), .trig_accept_o(accepted)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d at cycle %0d", req, act, exp, cycles);
        end
    endtask

    function automatic bit exp_busy();
        return (m_free == 0) || (mq.size() > 48);
    endfunction

    function automatic int exp_kind(input bit ins, input bit b);
        return ins ? (b ? 1 : 2) : 0;
    endfunction

    task automatic step(input bit t, input bit r, input bit d,
                        input bit v, input logic [DW-1:0] w, input bit rd);
        bit b, ins, acc, push, pop;
        @(negedge clk);
        trig = t; rel = r; done = d; dv = v; dd = w; dr = rd;
        #1;
        b   = exp_busy();
        ins = (b != m_rep);
        check("R6 busy", busy, b);
        check("R4 free slices", slices_free, m_free);
        check("R5 queue fill", frames, mq.size());
        check("R3 head empty mark", head_empty, (mq.size() != 0) ? mq[0] : 1'b0);
        check("R2 total count", total, m_total);
        check("R2 accepted count", accepted, m_acc);
        check("R10 accepted le total", int'(accepted <= total), 1);
        check("R7 out valid", dout_valid, ins || v);
        if (ins || v) begin
            check("R7 out kind", dout_kind, exp_kind(ins, b));
            check("R8 out data", dout_data, ins ? 0 : w);
        end
        check("R8 din ready", din_ready, rd && !ins);
        acc  = t && (m_free != 0);
        push = t && (mq.size() != 64);
        pop  = d && (mq.size() != 0);
        if (r && m_free != 3) m_free++;
        if (acc) m_free--;
        if (pop) void'(mq.pop_front());
        if (push) mq.push_back(!acc);
        m_total += int'(t);
        m_acc   += int'(acc);
        if (ins && rd) m_rep = b;   // R9 announce state moves only on accept
    endtask

    initial begin
        int unsigned seed;
        seed = $urandom(32'd20240607);
        rst = 1'b1; trig = 0; rel = 0; done = 0; dv = 0; dd = '0; dr = 0;
        m_free = 3; m_total = 0; m_acc = 0; m_rep = 0; mq.delete();
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;
        // R1 reset state
        step(0, 0, 0, 0, 24'h0, 1);
        check("R1 reset busy low", busy, 0);
        check("R1 reset free", slices_free, 3);
        // R2 fill slices while data flows, R7 busy-on arrives mid stream
        for (int i = 0; i < 3; i++) step(1, 0, 0, 1, 24'hA0 + DW'(i), 1);
        // R8 stall on busy word, data held
        step(0, 0, 0, 1, 24'h0BEEF, 0);
        step(0, 0, 0, 1, 24'h0BEEF, 0);
        step(0, 0, 0, 1, 24'h0BEEF, 1);
        step(0, 0, 0, 1, 24'h0BEEF, 1);
        // R3 rejected triggers, then R4 release with reject in one cycle
        step(1, 0, 0, 0, 24'h0, 1);
        step(1, 1, 0, 0, 24'h0, 1);
        // R4 alloc and release at one free slice
        step(1, 1, 0, 0, 24'h0, 1);
        // R5 pop through heads to reach the empty-marked entries
        for (int i = 0; i < 4; i++) step(0, 0, 1, 1, 24'h1234, 1);
        // R9 busy bounce before announce accepted
        step(0, 1, 0, 0, 24'h0, 1);
        step(0, 0, 0, 0, 24'h0, 1);
        step(1, 0, 0, 1, 24'h55, 0);
        step(1, 0, 0, 1, 24'h55, 0);
        step(0, 1, 0, 1, 24'h55, 0);
        step(0, 1, 0, 1, 24'h55, 0);
        step(0, 0, 0, 1, 24'h55, 1);
        // R6 queue-level busy: trigger with release each cycle
        for (int i = 0; i < 70; i++) step(1, 1, 0, 1, DW'(i), 1);
        for (int i = 0; i < 70; i++) step(0, 1, 1, 0, 24'h0, (i % 3) != 0);
        // R4 release with all free is ignored
        step(0, 1, 0, 0, 24'h0, 1);
        step(0, 0, 0, 0, 24'h0, 1);
        // random mix
        for (int i = 0; i < 4000; i++) begin
            step(($urandom % 100) < 35, ($urandom % 100) < 25, ($urandom % 100) < 22,
                 ($urandom % 100) < 70, DW'($urandom), ($urandom % 100) < 75);
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 100000) begin
                errors++;
                $display("FAIL watchdog: actual %0d expected below %0d", cycles, 100000);
                $display("Simulation finished: %0d checks, %0d errors", checks, errors);
                $finish;
            end
        end
    end

endmodule